// File: doc/BRIEF.md
# Inter-Device Address Translation Unit

This block converts addresses that cross a chip-to-chip memory window. On the sending side, a master on the local bus issues an address inside the window together with its privilege ID. The block keeps the in-window part of the address and stamps the privilege ID into the top nibble before the address goes out on the link. On the receiving side, the block takes an address from the link and splits it into a privilege ID, a segment number and an in-segment offset. It looks up a 64-entry segment table and produces the local memory address as the segment base plus the offset.

The table index is built from the two low privilege-ID bits and the segment number. Two masters that use the same window address can therefore land in different remote memory regions. Each table entry holds a base address and a power-of-two length code. An offset outside the programmed length is flagged as an error, and in that case no address is produced. A single-cycle write port loads table entries. Both paths are registered and have one cycle of latency.

Top module: `xlink_addr_xlate`

## Requirements
- R1: The outbound path keeps address bits 27:0 unchanged and discards local bits 31:28. The result appears on `ob_out_addr` with `ob_out_valid` one cycle after `ob_valid`.
- R2: The outbound result carries the issuing privilege ID `ob_priv` in bits 31:28.
- R3: For each inbound lookup, `ib_out_priv` reports bits 31:28 of the received address, one cycle after `ib_valid`, together with `ib_out_valid`.
- R4: The table index of an inbound address is bits 29:24: bits 29:28 are the low privilege bits and bits 27:24 are the segment number, so the index is (priv[1:0] << 4) | segment, which selects one of 64 entries.
- R5: A lookup that is in range returns the entry base plus bits 23:0 of the received address, modulo 2^32, with `ib_out_err` low.
- R6: The same window offset reaches different bases for different privilege IDs. With base 0x8C000000 in entry 0x0D and base 0x8F000000 in entry 0x1D, address 0x0D000000 maps to 0x8C000000 and address 0x1D000000 maps to 0x8F000000.
- R7: A length code c from 1 to 24 gives a segment of 2^c bytes. A code above 24 gives 2^24 bytes. Code 0 marks the entry as unmapped, so every access to it is out of range.
- R8: An access whose offset does not fit the entry's segment raises `ib_out_err`, and `ib_out_addr` is then 0.
- R9: A table write takes effect for lookups issued in the following cycle. A lookup issued in the same cycle as a write to its entry sees the old contents.
- R10: After reset both output valids are low and every table entry is unmapped.
- R11: Received address bits 31:30 have no effect on the table index or on the translated address; they only appear in `ib_out_priv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tw_en | input | 1 | Table write strobe |
| tw_idx | input | 6 | Entry to write |
| tw_base | input | 32 | Base address for the entry |
| tw_len | input | 5 | Length code for the entry |
| ob_valid | input | 1 | Outbound request valid |
| ob_addr | input | 32 | Local bus address |
| ob_priv | input | 4 | Issuing master privilege ID |
| ob_out_valid | output | 1 | Outbound result valid |
| ob_out_addr | output | 32 | Address placed on the link |
| ib_valid | input | 1 | Inbound request valid |
| ib_addr | input | 32 | Address received from the link |
| ib_out_valid | output | 1 | Inbound result valid |
| ib_out_err | output | 1 | Offset outside segment |
| ib_out_priv | output | 4 | Remote privilege ID from the address |
| ib_out_addr | output | 32 | Translated local memory address |

## Verification
On every cycle, the assertions check the outbound bit placement against the inputs of the previous cycle, the one-cycle latency of both paths, and that the remote privilege ID is passed through. They also check that an error result never carries an address. Whether the right entry was selected, how the base and offset combine, how the length codes are decoded, and whether a write is visible in the same cycle or the next depend on table contents. Only the bench's scenarios, which program chosen entries and compare against computed addresses, can show these.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    parameter int unsigned ADDR_W = 32;
    parameter int unsigned PRIV_W = 4;
    parameter int unsigned SEGN_W = 4;
    parameter int unsigned IDXP_W = 2;
    parameter int unsigned LEN_W  = 5;

    localparam int unsigned WIN_W  = ADDR_W - PRIV_W;
    localparam int unsigned OFFS_W = WIN_W - SEGN_W;
    localparam int unsigned IDX_W  = SEGN_W + IDXP_W;
    localparam int unsigned DEPTH  = 1 << IDX_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [PRIV_W-1:0] priv_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [OFFS_W-1:0] offs_t;
    typedef logic [OFFS_W:0]   wide_offs_t;

    typedef struct packed {
        addr_t base;
        len_t  len;
    } seg_entry_t;

    typedef struct packed {
        logic  valid;
        priv_t priv;
        idx_t  idx;
        offs_t offs;
    } ib_req_t;

    typedef struct packed {
        logic  valid;
        logic  err;
        priv_t priv;
        addr_t addr;
    } ib_rsp_t;

    // Mask of offset bits allowed by a length code; code 0 allows nothing.
    function automatic offs_t len_mask(input len_t code);
        wide_offs_t one_hot;
        int unsigned eff;
        if (code == '0) return '0;
        eff = (int'(code) > int'(OFFS_W)) ? OFFS_W : int'(code);
        one_hot = wide_offs_t'(1) << eff;
        one_hot = one_hot - wide_offs_t'(1);
        return one_hot[OFFS_W-1:0];
    endfunction

    function automatic ib_req_t split_addr(input logic valid, input addr_t a);
        ib_req_t r;
        r.valid = valid;
        r.priv  = a[ADDR_W-1:WIN_W];
        r.idx   = a[OFFS_W+IDX_W-1:OFFS_W];
        r.offs  = a[OFFS_W-1:0];
        return r;
    endfunction
endpackage

// File: rtl/xlat_outbound.sv
module xlat_outbound
    import xlat_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  addr_t in_addr,
    input  priv_t in_priv,
    output logic  out_valid,
    output addr_t out_addr
);
    logic unused_hi;
    assign unused_hi = ^in_addr[ADDR_W-1:WIN_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_addr <= {in_priv, in_addr[WIN_W-1:0]};
        end
    end
endmodule

// File: rtl/xlat_seg_table.sv
module xlat_seg_table
    import xlat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  idx_t       wr_idx,
    input  seg_entry_t wr_data,
    input  idx_t       rd_idx,
    output seg_entry_t rd_data
);
    seg_entry_t entries [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entries[g] <= '0;
            end else if (wr_en && (wr_idx == idx_t'(g))) begin
                entries[g] <= wr_data;
            end
        end
    end

    assign rd_data = entries[rd_idx];
endmodule

// File: rtl/xlat_inbound.sv
module xlat_inbound
    import xlat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  addr_t      in_addr,
    output idx_t       tbl_idx,
    input  seg_entry_t tbl_entry,
    output ib_rsp_t    rsp
);
    ib_req_t req;
    offs_t   mask;
    logic    oob;
    addr_t   sum;

    always_comb begin
        req     = split_addr(in_valid, in_addr);
        tbl_idx = req.idx;
        mask    = len_mask(tbl_entry.len);
        oob     = (tbl_entry.len == '0) || ((req.offs & ~mask) != '0);
        sum     = tbl_entry.base + addr_t'(req.offs & mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.valid <= req.valid;
            if (req.valid) begin
                rsp.err  <= oob;
                rsp.priv <= req.priv;
                rsp.addr <= oob ? '0 : sum;
            end
        end
    end
endmodule

// File: rtl/xlink_addr_xlate.sv
module xlink_addr_xlate
    import xlat_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tw_en,
    input  logic [IDX_W-1:0]    tw_idx,
    input  logic [ADDR_W-1:0]   tw_base,
    input  logic [LEN_W-1:0]    tw_len,
    input  logic                ob_valid,
    input  logic [ADDR_W-1:0]   ob_addr,
    input  logic [PRIV_W-1:0]   ob_priv,
    output logic                ob_out_valid,
    output logic [ADDR_W-1:0]   ob_out_addr,
    input  logic                ib_valid,
    input  logic [ADDR_W-1:0]   ib_addr,
    output logic                ib_out_valid,
    output logic                ib_out_err,
    output logic [PRIV_W-1:0]   ib_out_priv,
    output logic [ADDR_W-1:0]   ib_out_addr
);
    idx_t       rd_idx;
    seg_entry_t rd_entry;
    seg_entry_t wr_entry;
    ib_rsp_t    rsp;

    assign wr_entry = '{base: tw_base, len: tw_len};

    xlat_outbound u_ob (
        .clk(clk), .rst(rst),
        .in_valid(ob_valid), .in_addr(ob_addr), .in_priv(ob_priv),
        .out_valid(ob_out_valid), .out_addr(ob_out_addr)
    );

    xlat_seg_table u_tbl (
        .clk(clk), .rst(rst),
        .wr_en(tw_en), .wr_idx(tw_idx), .wr_data(wr_entry),
        .rd_idx(rd_idx), .rd_data(rd_entry)
    );

    xlat_inbound u_ib (
        .clk(clk), .rst(rst),
        .in_valid(ib_valid), .in_addr(ib_addr),
        .tbl_idx(rd_idx), .tbl_entry(rd_entry), .rsp(rsp)
    );

    assign ib_out_valid = rsp.valid;
    assign ib_out_err   = rsp.err;
    assign ib_out_priv  = rsp.priv;
    assign ib_out_addr  = rsp.addr;
endmodule

// File: rtl/xlat_checker.sv
module xlat_checker
    import xlat_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  ob_valid,
    input addr_t ob_addr,
    input priv_t ob_priv,
    input logic  ob_out_valid,
    input addr_t ob_out_addr,
    input logic  ib_valid,
    input addr_t ib_addr,
    input logic  ib_out_valid,
    input logic  ib_out_err,
    input priv_t ib_out_priv,
    input addr_t ib_out_addr
);
    p_ob_latency_r1: assert property (@(posedge clk) disable iff (rst)
        ob_valid |=> ob_out_valid);
    p_ob_low_bits_r1: assert property (@(posedge clk) disable iff (rst)
        ob_valid |=> ob_out_addr[WIN_W-1:0] == $past(ob_addr[WIN_W-1:0]));
    p_ob_priv_r2: assert property (@(posedge clk) disable iff (rst)
        ob_valid |=> ob_out_addr[ADDR_W-1:WIN_W] == $past(ob_priv));
    p_ib_latency_r3: assert property (@(posedge clk) disable iff (rst)
        ib_valid |=> ib_out_valid);
    p_ib_priv_r3: assert property (@(posedge clk) disable iff (rst)
        ib_valid |=> ib_out_priv == $past(ib_addr[ADDR_W-1:WIN_W]));
    p_err_no_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (ib_out_valid && ib_out_err) |-> ib_out_addr == '0);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (!ib_valid && !ob_valid) |=> (!ib_out_valid && !ob_out_valid));
endmodule

bind xlink_addr_xlate xlat_checker u_chk (
    .clk(clk), .rst(rst),
    .ob_valid(ob_valid), .ob_addr(ob_addr), .ob_priv(ob_priv),
    .ob_out_valid(ob_out_valid), .ob_out_addr(ob_out_addr),
    .ib_valid(ib_valid), .ib_addr(ib_addr),
    .ib_out_valid(ib_out_valid), .ib_out_err(ib_out_err),
    .ib_out_priv(ib_out_priv), .ib_out_addr(ib_out_addr)
);

// File: tb/xlink_addr_xlate_tb.sv
module xlink_addr_xlate_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        tw_en;
    logic [5:0]  tw_idx;
    logic [31:0] tw_base;
    logic [4:0]  tw_len;
    logic        ob_valid;
    logic [31:0] ob_addr;
    logic [3:0]  ob_priv;
    logic        ob_out_valid;
    logic [31:0] ob_out_addr;
    logic        ib_valid;
    logic [31:0] ib_addr;
    logic        ib_out_valid;
    logic        ib_out_err;
    logic [3:0]  ib_out_priv;
    logic [31:0] ib_out_addr;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    xlink_addr_xlate u_dut (
        .clk(clk), .rst(rst),
        .tw_en(tw_en), .tw_idx(tw_idx), .tw_base(tw_base), .tw_len(tw_len),
        .ob_valid(ob_valid), .ob_addr(ob_addr), .ob_priv(ob_priv),
        .ob_out_valid(ob_out_valid), .ob_out_addr(ob_out_addr),
        .ib_valid(ib_valid), .ib_addr(ib_addr),
        .ib_out_valid(ib_out_valid), .ib_out_err(ib_out_err),
        .ib_out_priv(ib_out_priv), .ib_out_addr(ib_out_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic tbl_write(input logic [5:0] idx, input logic [31:0] base, input logic [4:0] len);
        @(negedge clk);
        tw_en = 1'b1; tw_idx = idx; tw_base = base; tw_len = len;
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    task automatic run_outbound(input logic [31:0] a, input logic [3:0] p, input logic [31:0] exp);
        @(negedge clk);
        ob_valid = 1'b1; ob_addr = a; ob_priv = p;
        @(posedge clk); #1;
        chk(ob_out_valid == 1'b1, "R1 outbound valid", {31'd0, ob_out_valid}, 32'd1);
        chk(ob_out_addr == exp, "R1/R2 outbound address", ob_out_addr, exp);
        @(negedge clk);
        ob_valid = 1'b0;
    endtask

    task automatic run_inbound(input logic [31:0] a, input bit exp_err, input logic [31:0] exp,
                               input string tag);
        @(negedge clk);
        ib_valid = 1'b1; ib_addr = a;
        @(posedge clk); #1;
        chk(ib_out_valid == 1'b1, {tag, " valid"}, {31'd0, ib_out_valid}, 32'd1);
        chk(ib_out_err == exp_err, {tag, " err"}, {31'd0, ib_out_err}, {31'd0, exp_err});
        chk(ib_out_addr == exp, {tag, " addr"}, ib_out_addr, exp);
        chk(ib_out_priv == a[31:28], {tag, " R3 priv"}, {28'd0, ib_out_priv}, {28'd0, a[31:28]});
        @(negedge clk);
        ib_valid = 1'b0;
    endtask

    task automatic test_reset;
        #1;
        chk(ob_out_valid == 1'b0, "R10 ob valid after reset", {31'd0, ob_out_valid}, 32'd0);
        chk(ib_out_valid == 1'b0, "R10 ib valid after reset", {31'd0, ib_out_valid}, 32'd0);
        run_inbound(32'h0080_0000, 1'b1, 32'h0, "R10 unmapped after reset");
    endtask

    task automatic test_outbound;
        run_outbound(32'hABCD_1234, 4'h3, 32'h3BCD_1234);
        run_outbound(32'hFFFF_FFFF, 4'h0, 32'h0FFF_FFFF);
        run_outbound(32'h0000_0000, 4'hF, 32'hF000_0000);
    endtask

    task automatic test_lookup;
        tbl_write(6'h00, 32'h1000_0000, 5'd24);
        tbl_write(6'h0D, 32'h8C00_0000, 5'd24);
        tbl_write(6'h1D, 32'h8F00_0000, 5'd24);
        run_inbound(32'h0080_0000, 1'b0, 32'h1080_0000, "R4/R5 segment 0");
        run_inbound(32'h0D00_0000, 1'b0, 32'h8C00_0000, "R6 priv 0");
        run_inbound(32'h1D00_0000, 1'b0, 32'h8F00_0000, "R6 priv 1");
        run_inbound(32'h1D12_3456, 1'b0, 32'h8F12_3456, "R5 offset add");
        run_inbound(32'hC080_0000, 1'b0, 32'h1080_0000, "R11 upper priv bits ignored");
    endtask

    task automatic test_lengths;
        tbl_write(6'h2A, 32'h9000_0000, 5'd12);
        tbl_write(6'h33, 32'hA000_0000, 5'd31);
        tbl_write(6'h05, 32'hFFFF_FF00, 5'd8);
        run_inbound(32'h2A00_0FFF, 1'b0, 32'h9000_0FFF, "R7 last byte of 4KB");
        run_inbound(32'h2A00_1000, 1'b1, 32'h0, "R8 one past 4KB");
        run_inbound(32'h33FF_FFFF, 1'b0, 32'hA0FF_FFFF, "R7 clamped code");
        run_inbound(32'h3F00_0000, 1'b1, 32'h0, "R7 code 0 unmapped");
        run_inbound(32'h0500_00FF, 1'b0, 32'hFFFF_FFFF, "R5 top of space");
        run_inbound(32'h0500_0100, 1'b1, 32'h0, "R8 beyond 256B");
    endtask

    task automatic test_write_timing;
        @(negedge clk);
        tw_en = 1'b1; tw_idx = 6'h0D; tw_base = 32'h7000_0000; tw_len = 5'd24;
        ib_valid = 1'b1; ib_addr = 32'h0D00_0010;
        @(posedge clk); #1;
        chk(ib_out_addr == 32'h8C00_0010, "R9 same-cycle sees old", ib_out_addr, 32'h8C00_0010);
        @(negedge clk);
        tw_en = 1'b0;
        ib_valid = 1'b1; ib_addr = 32'h0D00_0010;
        @(posedge clk); #1;
        chk(ib_out_addr == 32'h7000_0010, "R9 next cycle sees new", ib_out_addr, 32'h7000_0010);
        chk(ib_out_err == 1'b0, "R9 next cycle err", {31'd0, ib_out_err}, 32'd0);
        @(negedge clk);
        ib_valid = 1'b0;
        @(posedge clk); #1;
        chk(ib_out_valid == 1'b0, "R3 valid drops", {31'd0, ib_out_valid}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; tw_en = 1'b0; tw_idx = '0; tw_base = '0; tw_len = '0;
        ob_valid = 1'b0; ob_addr = '0; ob_priv = '0; ib_valid = 1'b0; ib_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_outbound();
        test_lookup();
        test_lengths();
        test_write_timing();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule